// File: doc/BRIEF.md
# Mixed-Cell Boundary Scan Register

This block is the boundary scan data register of a chip's test port. It strings one scan cell per signal pin into a single serial path between the test data input and the test data output. Three cell kinds share the path. A bidirectional pin and a tri-state output pin each take two scan bits, one for data and one for the output enable. An input-only pin takes one bit. The default build has 141 bidirectional cells, 89 output cells and 29 input cells, which gives a 489-bit path.

A test access port controller drives the block through one-cycle strobes on the test clock: capture, shift, update-data, update-instruction and test-logic-reset. Alongside the update-instruction strobe, the instruction decoder supplies two flags that say whether the new instruction is the external test or the sample/preload instruction. The block keeps its own copy of the active mode. In external test mode, the update latches drive the pad outputs and pad enables. In every other mode, the pads pass the core values through unchanged.

Top module: `bscan_chain`

## Requirements
- R1: Scan bit 0 is nearest the serial output. Bidirectional cell k holds data at bit 2k and enable at bit 2k+1. Output cell j holds data at bit 2·NB+2j and enable at bit 2·NB+2j+1. Input cell i sits at bit 2·(NB+NO)+i. The path is 2·NB+2·NO+NI bits long.
- R2: On each shift strobe in a scan mode, every bit moves one place toward bit 0 and the test data input enters the top bit. After L shifts, the word read out is the word shifted in.
- R3: On a capture strobe in a scan mode, the capture sources are as follows. Bidirectional data and input cells take their pad input. Bidirectional enables take the core enable. Output cells take the core data and the core enable.
- R4: The update latches change only on an update-data strobe in a scan mode. Shifting leaves the pads unchanged until that strobe.
- R5: Outside external test mode, pad_out equals core_out and pad_oe equals core_oe.
- R6: An update-instruction strobe with the external-test flag puts the held latch values on the pads in the next cycle, with no update-data strobe needed. Pad p takes data from latch bit 2p and enable from latch bit 2p+1.
- R7: When neither scan instruction is active, capture, shift and update-data strobes leave the path and the latches untouched.
- R8: A test-logic-reset strobe, or rst_n low at a clock edge, clears every update latch to data 0 and enable 0. It also returns the mode to non-scan.
- R9: The serial output changes only on the falling clock edge. In a scan mode it then shows scan bit 0. Outside a scan mode it holds its value.
- R10: After reset, tdo is 0 and the pads pass the core values through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial test data in |
| st_capture | input | 1 | Capture-data strobe |
| st_shift | input | 1 | Shift-data strobe |
| st_update_dr | input | 1 | Update-data strobe |
| st_update_ir | input | 1 | Update-instruction strobe |
| st_reset | input | 1 | Test-logic-reset strobe |
| ins_extest | input | 1 | New instruction is external test |
| ins_sample | input | 1 | New instruction is sample/preload |
| core_out | input | NB+NO | Core-side output data per driving pin |
| core_oe | input | NB+NO | Core-side output enable per driving pin |
| pad_in | input | NB+NI | Pad input values: bidirectional pins then input pins |
| pad_out | output | NB+NO | Pad-side output data |
| pad_oe | output | NB+NO | Pad-side output enable |
| tdo | output | 1 | Serial data toward the test data output |

## Verification
The assertions assume that the controller raises at most one of capture, shift, update-data and update-instruction in any cycle. They also assume that the two instruction flags are never high together when update-instruction fires. The bench keeps to both assumptions: it raises each strobe alone for one cycle and drives the flags only in those two legal combinations. It sweeps every pad input pattern of a small configuration and derives the core values from the sweep index. For each pattern it checks capture layout, shift-through, latch isolation, mode switching and reset clearing.

// File: rtl/bscan_pkg.sv
// Package: shared mode encoding and size helper for the boundary scan register.
package bscan_pkg;

    typedef enum logic [1:0] {
        MODE_OTHER  = 2'd0,
        MODE_SAMPLE = 2'd1,
        MODE_EXTEST = 2'd2
    } bsr_mode_e;

    // Number of scan bits for a given mix of cell kinds.
    function automatic int unsigned chain_bits(int unsigned nb, int unsigned no, int unsigned ni);
        return 2 * nb + 2 * no + ni;
    endfunction

endpackage

// File: rtl/bscan_cell2.sv
// Two-bit scan cell for a pin that can drive: a data bit and an enable bit.
// Assumes: strobes arrive already gated by the active scan mode.
// Assumes: clr (test-logic-reset) outranks capture, and capture outranks shift.
// The serial path runs si -> q_oe -> q_d, and q_d feeds the next cell down.
module bscan_cell2 (
    input  logic tck,
    input  logic rst_n,
    input  logic clr,
    input  logic cap,
    input  logic shf,
    input  logic upd,
    input  logic si,
    input  logic cap_d,
    input  logic cap_oe,
    output logic q_d,
    output logic q_oe,
    output logic hold_d,
    output logic hold_oe
);

    // Capture/shift stage.
    always_ff @(posedge tck) begin
        if (!rst_n || clr) begin
            q_d  <= 1'b0;
            q_oe <= 1'b0;
        end else if (cap) begin
            q_d  <= cap_d;
            q_oe <= cap_oe;
        end else if (shf) begin
            q_oe <= si;
            q_d  <= q_oe;
        end
    end

    // Update latch: loads only on the update strobe, so the pins stay still while data shifts.
    always_ff @(posedge tck) begin
        if (!rst_n || clr) begin
            hold_d  <= 1'b0;
            hold_oe <= 1'b0;
        end else if (upd) begin
            hold_d  <= q_d;
            hold_oe <= q_oe;
        end
    end

    p_hold_stable_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (!upd && !clr) |=> $stable({hold_d, hold_oe}));

    p_capture_src_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (cap && !clr) |=> (q_d == $past(cap_d) && q_oe == $past(cap_oe)));

    p_shift_step_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (shf && !cap && !clr) |=> (q_d == $past(q_oe) && q_oe == $past(si)));

    p_clear_off_r8: assert property (@(posedge tck) disable iff (!rst_n)
        clr |=> (!hold_d && !hold_oe));

endmodule

// File: rtl/bscan_cell1.sv
// One-bit scan cell for an input-only pin. It has no update latch, because the
// pin drives nothing. Assumes: strobes arrive already gated by the active scan mode.
module bscan_cell1 (
    input  logic tck,
    input  logic rst_n,
    input  logic clr,
    input  logic cap,
    input  logic shf,
    input  logic si,
    input  logic cap_d,
    output logic q
);

    // Capture/shift stage.
    always_ff @(posedge tck) begin
        if (!rst_n || clr)  q <= 1'b0;
        else if (cap)       q <= cap_d;
        else if (shf)       q <= si;
    end

    p_in_capture_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (cap && !clr) |=> (q == $past(cap_d)));

endmodule

// File: rtl/bscan_tdo_retime.sv
// Falling-edge retime of the serial output. It follows scan bit 0 while a scan
// mode is active and holds otherwise. Assumes: rst_n is held across a falling edge.
module bscan_tdo_retime (
    input  logic tck,
    input  logic rst_n,
    input  logic sel,
    input  logic so,
    output logic tdo
);

    // Serial output register, clocked on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n)   tdo <= 1'b0;
        else if (sel) tdo <= so;
    end

    p_tdo_hold_r9: assert property (@(negedge tck) disable iff (!rst_n)
        !sel |=> $stable(tdo));

endmodule

// File: rtl/bscan_chain.sv
// Boundary scan data register with three cell kinds on one serial path.
// Order from the serial output: bidirectional cells, then output cells, then input cells.
// Assumes: controller strobes are one-cycle pulses on tck, at most one per cycle.
// Assumes: the instruction flags are mutually exclusive when st_update_ir is high.
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int unsigned N_BIDIR = 141,
    parameter int unsigned N_OUT   = 89,
    parameter int unsigned N_IN    = 29
) (
    input  logic                     tck,
    input  logic                     rst_n,
    input  logic                     tdi,
    input  logic                     st_capture,
    input  logic                     st_shift,
    input  logic                     st_update_dr,
    input  logic                     st_update_ir,
    input  logic                     st_reset,
    input  logic                     ins_extest,
    input  logic                     ins_sample,
    input  logic [N_BIDIR+N_OUT-1:0] core_out,
    input  logic [N_BIDIR+N_OUT-1:0] core_oe,
    input  logic [N_BIDIR+N_IN-1:0]  pad_in,
    output logic [N_BIDIR+N_OUT-1:0] pad_out,
    output logic [N_BIDIR+N_OUT-1:0] pad_oe,
    output logic                     tdo
);

    localparam int unsigned NDRV    = N_BIDIR + N_OUT;
    localparam int unsigned LEN     = chain_bits(N_BIDIR, N_OUT, N_IN);
    localparam int unsigned IN_BASE = 2 * NDRV;

    bsr_mode_e        mode_q;
    logic             sel, ext;
    logic             cap_en, shf_en, upd_en;
    logic [LEN:0]     ch;
    logic [NDRV-1:0]  hold_d, hold_oe;

    // Active mode register: set by update-instruction, cleared by test-logic-reset.
    always_ff @(posedge tck) begin
        if (!rst_n || st_reset)  mode_q <= MODE_OTHER;
        else if (st_update_ir)   mode_q <= ins_extest ? MODE_EXTEST :
                                           ins_sample ? MODE_SAMPLE : MODE_OTHER;
    end

    // Strobe gating: the path reacts only while a scan instruction is active.
    always_comb begin
        sel    = (mode_q != MODE_OTHER);
        ext    = (mode_q == MODE_EXTEST);
        cap_en = st_capture   && sel;
        shf_en = st_shift     && sel;
        upd_en = st_update_dr && sel;
    end

    assign ch[LEN] = tdi;

    // Bidirectional cells: data captures the pad, enable captures the core.
    for (genvar k = 0; k < N_BIDIR; k++) begin : g_bidir
        bscan_cell2 u_cell (
            .tck     (tck),
            .rst_n   (rst_n),
            .clr     (st_reset),
            .cap     (cap_en),
            .shf     (shf_en),
            .upd     (upd_en),
            .si      (ch[2*k+2]),
            .cap_d   (pad_in[k]),
            .cap_oe  (core_oe[k]),
            .q_d     (ch[2*k]),
            .q_oe    (ch[2*k+1]),
            .hold_d  (hold_d[k]),
            .hold_oe (hold_oe[k])
        );
    end

    // Tri-state output cells: both bits capture the core side.
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        localparam int unsigned P = N_BIDIR + j;
        bscan_cell2 u_cell (
            .tck     (tck),
            .rst_n   (rst_n),
            .clr     (st_reset),
            .cap     (cap_en),
            .shf     (shf_en),
            .upd     (upd_en),
            .si      (ch[2*P+2]),
            .cap_d   (core_out[P]),
            .cap_oe  (core_oe[P]),
            .q_d     (ch[2*P]),
            .q_oe    (ch[2*P+1]),
            .hold_d  (hold_d[P]),
            .hold_oe (hold_oe[P])
        );
    end

    // Input-only cells: one bit each, capturing the pad.
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        bscan_cell1 u_cell (
            .tck   (tck),
            .rst_n (rst_n),
            .clr   (st_reset),
            .cap   (cap_en),
            .shf   (shf_en),
            .si    (ch[IN_BASE+i+1]),
            .cap_d (pad_in[N_BIDIR+i]),
            .q     (ch[IN_BASE+i])
        );
    end

    // Pad drive: the latches under external test, the core otherwise.
    always_comb begin
        pad_out = ext ? hold_d  : core_out;
        pad_oe  = ext ? hold_oe : core_oe;
    end

    bscan_tdo_retime u_tdo (
        .tck   (tck),
        .rst_n (rst_n),
        .sel   (sel),
        .so    (ch[0]),
        .tdo   (tdo)
    );

    p_ins_onehot_r6: assert property (@(posedge tck) disable iff (!rst_n)
        st_update_ir |-> $onehot0({ins_extest, ins_sample}));

    p_strobe_excl_r3: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({st_capture, st_shift, st_update_dr, st_update_ir}));

    p_extest_apply_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (st_update_ir && ins_extest && !st_reset) |=> (pad_out == hold_d && pad_oe == hold_oe));

    p_reset_pass_r8: assert property (@(posedge tck) disable iff (!rst_n)
        st_reset |=> (pad_out == core_out && pad_oe == core_oe));

endmodule

// File: tb/bscan_chain_bench.sv
`timescale 1ns/1ps
module bscan_chain_bench;

    localparam int NB = 3;
    localparam int NO = 2;
    localparam int NI = 2;
    localparam int NP = NB + NO;
    localparam int NQ = NB + NI;
    localparam int L  = 2 * NB + 2 * NO + NI;

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          tdi = 1'b0;
    logic          st_capture = 1'b0, st_shift = 1'b0, st_update_dr = 1'b0;
    logic          st_update_ir = 1'b0, st_reset = 1'b0;
    logic          ins_extest = 1'b0, ins_sample = 1'b0;
    logic [NP-1:0] core_out = '0, core_oe = '0;
    logic [NQ-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          tdo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 tck = ~tck;

    bscan_chain #(.N_BIDIR(NB), .N_OUT(NO), .N_IN(NI)) u_bscan_chain (
        .tck(tck), .rst_n(rst_n), .tdi(tdi),
        .st_capture(st_capture), .st_shift(st_shift), .st_update_dr(st_update_dr),
        .st_update_ir(st_update_ir), .st_reset(st_reset),
        .ins_extest(ins_extest), .ins_sample(ins_sample),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .tdo(tdo)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to 1 ns after the next rising edge.
    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic ir_load(input bit ext, input bit smp);
        ins_extest = ext; ins_sample = smp; st_update_ir = 1'b1;
        step();
        st_update_ir = 1'b0; ins_extest = 1'b0; ins_sample = 1'b0;
    endtask

    task automatic pulse_capture();
        st_capture = 1'b1; step(); st_capture = 1'b0;
    endtask

    task automatic pulse_update();
        st_update_dr = 1'b1; step(); st_update_dr = 1'b0;
    endtask

    // Shift a word in (bit 0 first) and record tdo. When ck is set, also check
    // that tdo moves only at the falling edge (R9).
    task automatic shift_word(input logic [L-1:0] din, input bit ck, output logic [L-1:0] dout);
        for (int i = 0; i < L; i++) begin
            logic pre;
            #2; pre = tdo;
            #2; dout[i] = tdo;
            if (ck && i > 0) chk(pre == dout[i-1], "R9 tdo before fall", pre, dout[i-1]);
            tdi = din[i]; st_shift = 1'b1;
            step();
            st_shift = 1'b0;
        end
    endtask

    // R1/R3 expected capture word.
    function automatic logic [L-1:0] cap_word(logic [NQ-1:0] pin, logic [NP-1:0] co, logic [NP-1:0] coe);
        logic [L-1:0] w = '0;
        for (int k = 0; k < NB; k++) begin w[2*k] = pin[k]; w[2*k+1] = coe[k]; end
        for (int j = 0; j < NO; j++) begin w[2*(NB+j)] = co[NB+j]; w[2*(NB+j)+1] = coe[NB+j]; end
        for (int i = 0; i < NI; i++) w[2*NP+i] = pin[NB+i];
        return w;
    endfunction

    function automatic logic [NP-1:0] w_out(logic [L-1:0] w);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = w[2*p];
        return r;
    endfunction

    function automatic logic [NP-1:0] w_oe(logic [L-1:0] w);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = w[2*p+1];
        return r;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge tck);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [L-1:0] d1, d2, d3, got, got2, exp;
        core_out = 5'h15; core_oe = 5'h0b;
        repeat (3) step();
        #4;
        chk(tdo == 1'b0, "R10 tdo reset", tdo, 0);
        chk(pad_out == core_out && pad_oe == core_oe, "R10 pads pass", {pad_out, pad_oe}, {core_out, core_oe});
        rst_n = 1'b1;
        step();

        for (int idx = 0; idx < (1 << NQ); idx++) begin
            pad_in   = idx[NQ-1:0];
            core_out = NP'((idx * 13 + 5) % 32);
            core_oe  = NP'((idx * 11 + 3) % 32);
            d1 = L'(idx * 77 + 9);
            d2 = L'((idx * 389 + 1234) % 4096);
            d3 = ~d2 ^ L'(idx << 3);

            ir_load(1'b0, 1'b1);
            pulse_capture();
            shift_word(d1, 1'b1, got);
            exp = cap_word(pad_in, core_out, core_oe);
            chk(got == exp, "R1 R3 capture word", got, exp);
            shift_word(d2, 1'b1, got2);
            chk(got2 == d1, "R2 shift through", got2, d1);
            pulse_update();
            chk(pad_out == core_out && pad_oe == core_oe, "R5 sample pass", {pad_out, pad_oe}, {core_out, core_oe});

            ir_load(1'b1, 1'b0);
            chk(pad_out == w_out(d2) && pad_oe == w_oe(d2), "R6 extest at update-ir",
                {pad_out, pad_oe}, {w_out(d2), w_oe(d2)});
            shift_word(d3, 1'b1, got);
            chk(pad_out == w_out(d2) && pad_oe == w_oe(d2), "R4 pads still during shift",
                {pad_out, pad_oe}, {w_out(d2), w_oe(d2)});
            pulse_update();
            chk(pad_out == w_out(d3) && pad_oe == w_oe(d3), "R4 update-dr loads",
                {pad_out, pad_oe}, {w_out(d3), w_oe(d3)});

            ir_load(1'b0, 1'b0);
            chk(pad_out == core_out && pad_oe == core_oe, "R5 bypass pass", {pad_out, pad_oe}, {core_out, core_oe});
            pulse_capture();
            shift_word('1, 1'b0, got);
            pulse_update();
            ir_load(1'b1, 1'b0);
            chk(pad_out == w_out(d3) && pad_oe == w_oe(d3), "R7 latches untouched",
                {pad_out, pad_oe}, {w_out(d3), w_oe(d3)});

            st_reset = 1'b1; step(); st_reset = 1'b0;
            chk(pad_out == core_out && pad_oe == core_oe, "R8 mode cleared", {pad_out, pad_oe}, {core_out, core_oe});
            ir_load(1'b1, 1'b0);
            chk(pad_out == '0 && pad_oe == '0, "R8 latches cleared", {pad_out, pad_oe}, 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule